// File: doc/BRIEF.md
# Output Protection and Fault Controller

This block is the supervisory logic beside a bank of twelve power switches arranged as six low-side and six high-side drivers. It takes the commanded on/off state of each switch, two inhibit sources, and a set of digital fault indications: supply overvoltage and undervoltage, per-switch overcurrent, thermal prewarning, thermal shutdown and per-switch open-load. From these it drives the twelve gate enables and builds a 16-bit status word for the serial block next to it.

All fault delays are counted in ticks of a slow timebase enable. The supply-fail delay depends on the kind of fault, and for overvoltage also on a delay-select input. A persistent overcurrent shuts off only its own switch, and only after a delay that the same delay-select input picks. If the thermal prewarning is active, an overcurrent shuts the switch off without waiting. The short-seen flag, the supply-fail flag and the thermal lockout are all held until a status-reset request arrives. The supply-fail gating itself lifts as soon as the supply is back in range.

The status word keeps the positions that the serial block decodes: bit 0 is the prewarning, bits 1 to 12 are the per-switch status, bit 13 is short-seen, bit 14 is inhibited and bit 15 is supply-fail.

Top module: `drv_guard`

## Requirements
- R1: After reset, with no faults, no command and both inhibit sources inactive, `drv_en` is 0 and `stat` is 16'h0000.
- R2: With no fault and no inhibit, `drv_en[i]` equals `cmd_on[i]`. Index 2k is low-side switch k and index 2k+1 is high-side switch k. No enable is ever high while its command is low.
- R3: When `sw_run` is 0 or `inh_n` is 0, every `drv_en` bit is 0 and `stat[14]` is 1. When both return to 1, the enables follow the commands again.
- R4: A supply fault that persists sets `stat[15]` and clears all enables. The required duration is UV_TICKS ticks for undervoltage, OV_LONG_TICKS for overvoltage with `dly_long`=1, and OV_SHORT_TICKS for overvoltage with `dly_long`=0. If the fault clears before the delay expires, the count restarts from zero.
- R5: When the supply returns to normal after a supply-fail shutdown, the enables return in the same cycle. `stat[15]` stays 1 until `srst_req` is sampled high.
- R6: An overcurrent on a switch that is on must last SC_LONG_TICKS ticks (`dly_long`=1) or SC_SHORT_TICKS ticks (`dly_long`=0). Then only that switch is disabled and `stat[13]` is set. If the overcurrent clears before expiry, the count restarts.
- R7: Overcurrent on an active switch while `temp_warn` is 1 disables that switch at the next clock edge and sets `stat[13]`.
- R8: `srst_req` clears `stat[13]` and `stat[15]` and re-enables switches that were shut off for overcurrent. A fault trip in the same cycle wins over the clear.
- R9: `temp_shut` clears all enables and forces `stat` to 16'hFFFF at once. Both stay in force until `temp_shut` is 0 and a later `srst_req` is seen.
- R10: `stat[i+1]` reports switch i. When `olm_en`=1 and `cmd_on[i]`=0 it shows `open_ld[i]`. Otherwise it shows `drv_en[i]`.
- R11: `stat[0]` follows `temp_warn` combinationally with no latching, except under thermal shutdown.
- R12: Fault delays advance only in cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable for fault delays |
| cmd_on | input | 12 | Commanded switch states (2k low-side k, 2k+1 high-side k) |
| sw_run | input | 1 | Software run bit, 0 inhibits all outputs |
| inh_n | input | 1 | Hardware inhibit, 0 inhibits all outputs |
| olm_en | input | 1 | Open-load reporting enable |
| dly_long | input | 1 | Selects the long overvoltage and overcurrent delays |
| srst_req | input | 1 | Status-reset request, one cycle |
| sup_ov | input | 1 | Supply overvoltage comparator |
| sup_uv | input | 1 | Supply undervoltage comparator |
| ovc | input | 12 | Per-switch overcurrent comparators |
| open_ld | input | 12 | Per-switch open-load comparators |
| temp_warn | input | 1 | Thermal prewarning comparator |
| temp_shut | input | 1 | Thermal shutdown comparator |
| drv_en | output | 12 | Gate enables of the twelve switches |
| stat | output | 16 | Status word |

## Verification
A delay counter that is off by one shows as an enable dropping one tick early or late. A counter that is not restarted shows as a trip after a fault that was broken in two. Both appear on `drv_en` within one delay window of the stimulus. A latch that releases too early appears as `stat[13]`, `stat[15]` or the all-ones pattern leaving before a status-reset request. A latch that does not release appears as enables that stay low in the cycle after the request. A wrong per-switch mapping puts a zero in a different bit of `drv_en` or `stat`. A wrong choice of delay source appears as a trip at the other delay's tick count.

// File: rtl/drv_guard_pkg.sv
`timescale 1ns/1ps
package drv_guard_pkg;
    localparam int PAIRS = 6;
    localparam int NOUT  = 2 * PAIRS;

    // Status word layout, MSB first; positions are decoded by the serial block.
    typedef struct packed {
        logic            supply_fail;  // bit 15
        logic            inhibited;    // bit 14
        logic            short_seen;   // bit 13
        logic [NOUT-1:0] chan;         // bits 12..1
        logic            prewarn;      // bit 0
    } status_t;

    typedef enum logic [1:0] {
        SUP_OK    = 2'd0,
        SUP_COUNT = 2'd1,
        SUP_TRIP  = 2'd2
    } sup_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/dg_supply_mon.sv
`timescale 1ns/1ps
module dg_supply_mon
    import drv_guard_pkg::*;
#(
    parameter int OV_LONG_TICKS  = 480,
    parameter int OV_SHORT_TICKS = 112,
    parameter int UV_TICKS       = 448
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sup_ov,
    input  logic sup_uv,
    input  logic dly_long,
    input  logic clr,
    output logic gate_off,
    output logic fail_flag
);
    localparam int CW = $clog2(max_of(max_of(OV_LONG_TICKS, OV_SHORT_TICKS), UV_TICKS) + 1);
    localparam logic [CW-1:0] LIM_OVL = CW'(OV_LONG_TICKS - 1);
    localparam logic [CW-1:0] LIM_OVS = CW'(OV_SHORT_TICKS - 1);
    localparam logic [CW-1:0] LIM_UV  = CW'(UV_TICKS - 1);

    sup_state_t    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          bad;
    logic          trip_evt;

    assign bad      = sup_ov | sup_uv;
    assign lim      = sup_uv ? LIM_UV : (dly_long ? LIM_OVL : LIM_OVS);
    assign trip_evt = bad && (state != SUP_TRIP) && tick && (cnt >= lim);
    // Release follows the live comparator, not the registered state.
    assign gate_off = (state == SUP_TRIP) && bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SUP_OK;
            cnt       <= '0;
            fail_flag <= 1'b0;
        end else begin
            if (!bad) begin
                state <= SUP_OK;
                cnt   <= '0;
            end else if (trip_evt) begin
                state <= SUP_TRIP;
                cnt   <= '0;
            end else if (state != SUP_TRIP && tick) begin
                state <= SUP_COUNT;
                cnt   <= cnt + 1'b1;
            end
            if (trip_evt)
                fail_flag <= 1'b1;
            else if (clr)
                fail_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dg_short_chan.sv
`timescale 1ns/1ps
module dg_short_chan
    import drv_guard_pkg::*;
#(
    parameter int SC_LONG_TICKS  = 3200,
    parameter int SC_SHORT_TICKS = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ovc,
    input  logic active,
    input  logic warn,
    input  logic dly_long,
    input  logic clr,
    output logic off,
    output logic trip_evt
);
    localparam int CW = $clog2(max_of(SC_LONG_TICKS, SC_SHORT_TICKS) + 1);
    localparam logic [CW-1:0] LIM_L = CW'(SC_LONG_TICKS - 1);
    localparam logic [CW-1:0] LIM_S = CW'(SC_SHORT_TICKS - 1);

    logic [CW-1:0] cnt;
    logic          hit;

    assign hit      = ovc & active;
    assign trip_evt = hit && (warn || (tick && cnt >= (dly_long ? LIM_L : LIM_S)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            off <= 1'b0;
        end else begin
            if (!hit || trip_evt)
                cnt <= '0;
            else if (tick)
                cnt <= cnt + 1'b1;
            if (trip_evt)
                off <= 1'b1;
            else if (clr)
                off <= 1'b0;
        end
    end
endmodule

// File: rtl/dg_thermal_latch.sv
`timescale 1ns/1ps
module dg_thermal_latch (
    input  logic clk,
    input  logic rst,
    input  logic shut,
    input  logic clr,
    output logic hold
);
    logic lock;

    always_ff @(posedge clk) begin
        if (rst)
            lock <= 1'b0;
        else if (shut)
            lock <= 1'b1;
        else if (clr)
            lock <= 1'b0;
    end

    assign hold = lock | shut;
endmodule

// File: rtl/drv_guard.sv
`timescale 1ns/1ps
module drv_guard
    import drv_guard_pkg::*;
#(
    parameter int OV_LONG_TICKS  = 480,
    parameter int OV_SHORT_TICKS = 112,
    parameter int UV_TICKS       = 448,
    parameter int SC_LONG_TICKS  = 3200,
    parameter int SC_SHORT_TICKS = 400
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [NOUT-1:0] cmd_on,
    input  logic            sw_run,
    input  logic            inh_n,
    input  logic            olm_en,
    input  logic            dly_long,
    input  logic            srst_req,
    input  logic            sup_ov,
    input  logic            sup_uv,
    input  logic [NOUT-1:0] ovc,
    input  logic [NOUT-1:0] open_ld,
    input  logic            temp_warn,
    input  logic            temp_shut,
    output logic [NOUT-1:0] drv_en,
    output logic [15:0]     stat
);
    logic            run;
    logic            sup_off;
    logic            sup_flag;
    logic            therm_hold;
    logic            global_ok;
    logic            short_flag;
    logic [NOUT-1:0] sc_off;
    logic [NOUT-1:0] sc_trip;
    status_t         st;

    assign run       = sw_run & inh_n;
    assign global_ok = run & ~sup_off & ~therm_hold;
    assign drv_en    = cmd_on & ~sc_off & {NOUT{global_ok}};

    dg_supply_mon #(
        .OV_LONG_TICKS (OV_LONG_TICKS),
        .OV_SHORT_TICKS(OV_SHORT_TICKS),
        .UV_TICKS      (UV_TICKS)
    ) u_supply (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .sup_ov   (sup_ov),
        .sup_uv   (sup_uv),
        .dly_long (dly_long),
        .clr      (srst_req),
        .gate_off (sup_off),
        .fail_flag(sup_flag)
    );

    dg_thermal_latch u_therm (
        .clk (clk),
        .rst (rst),
        .shut(temp_shut),
        .clr (srst_req),
        .hold(therm_hold)
    );

    for (genvar i = 0; i < NOUT; i++) begin : g_chan
        dg_short_chan #(
            .SC_LONG_TICKS (SC_LONG_TICKS),
            .SC_SHORT_TICKS(SC_SHORT_TICKS)
        ) u_sc (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .ovc     (ovc[i]),
            .active  (drv_en[i]),
            .warn    (temp_warn),
            .dly_long(dly_long),
            .clr     (srst_req),
            .off     (sc_off[i]),
            .trip_evt(sc_trip[i])
        );
        assign st.chan[i] = (olm_en && !cmd_on[i]) ? open_ld[i] : drv_en[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            short_flag <= 1'b0;
        else if (|sc_trip)
            short_flag <= 1'b1;
        else if (srst_req)
            short_flag <= 1'b0;
    end

    assign st.supply_fail = sup_flag;
    assign st.inhibited   = ~run;
    assign st.short_seen  = short_flag;
    assign st.prewarn     = temp_warn;

    assign stat = therm_hold ? '1 : st;
endmodule

// File: rtl/dg_checker.sv
`timescale 1ns/1ps
module dg_checker
    import drv_guard_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NOUT-1:0] cmd_on,
    input logic            sw_run,
    input logic            inh_n,
    input logic            srst_req,
    input logic [NOUT-1:0] ovc,
    input logic            temp_warn,
    input logic            temp_shut,
    input logic [NOUT-1:0] drv_en,
    input logic [15:0]     stat
);
    p_enable_subset_r2: assert property (@(posedge clk) disable iff (rst)
        (drv_en & ~cmd_on) == '0);

    p_inhibit_off_r3: assert property (@(posedge clk) disable iff (rst)
        !(sw_run && inh_n) |-> (drv_en == '0 && stat[14]));

    p_psf_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (stat[15] && !srst_req) |=> stat[15]);

    p_warn_trip_r7: assert property (@(posedge clk) disable iff (rst)
        (temp_warn && |(ovc & drv_en)) |=> stat[13]);

    p_short_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (stat[13] && !srst_req) |=> stat[13]);

    p_shut_force_r9: assert property (@(posedge clk) disable iff (rst)
        temp_shut |-> (stat == 16'hFFFF && drv_en == '0));

    p_prewarn_follow_r11: assert property (@(posedge clk) disable iff (rst)
        (stat[0] != temp_warn) |-> (stat == 16'hFFFF));
endmodule

bind drv_guard dg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_on   (cmd_on),
    .sw_run   (sw_run),
    .inh_n    (inh_n),
    .srst_req (srst_req),
    .ovc      (ovc),
    .temp_warn(temp_warn),
    .temp_shut(temp_shut),
    .drv_en   (drv_en),
    .stat     (stat)
);

// File: tb/drv_guard_test.sv
`timescale 1ns/1ps
module drv_guard_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic [11:0] cmd_on = '0;
    logic        sw_run = 1'b1;
    logic        inh_n = 1'b1;
    logic        olm_en = 1'b0;
    logic        dly_long = 1'b0;
    logic        srst_req = 1'b0;
    logic        sup_ov = 1'b0;
    logic        sup_uv = 1'b0;
    logic [11:0] ovc = '0;
    logic [11:0] open_ld = '0;
    logic        temp_warn = 1'b0;
    logic        temp_shut = 1'b0;
    logic [11:0] drv_en;
    logic [15:0] stat;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    drv_guard #(
        .OV_LONG_TICKS (6),
        .OV_SHORT_TICKS(3),
        .UV_TICKS      (5),
        .SC_LONG_TICKS (8),
        .SC_SHORT_TICKS(4)
    ) uut (
        .clk(clk), .rst(rst), .tick(tick), .cmd_on(cmd_on), .sw_run(sw_run),
        .inh_n(inh_n), .olm_en(olm_en), .dly_long(dly_long), .srst_req(srst_req),
        .sup_ov(sup_ov), .sup_uv(sup_uv), .ovc(ovc), .open_ld(open_ld),
        .temp_warn(temp_warn), .temp_shut(temp_shut), .drv_en(drv_en), .stat(stat)
    );

    // cmd, sw_run, inh_n, olm_en, open_ld, temp_warn | expected drv_en, stat
    localparam logic [55:0] VEC [6] = '{
        {12'hFFF, 1'b1, 1'b1, 1'b0, 12'h000, 1'b0, 12'hFFF, 16'h1FFE},
        {12'hA5C, 1'b1, 1'b1, 1'b0, 12'hFFF, 1'b1, 12'hA5C, 16'h14B9},
        {12'h000, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0, 12'h000, 16'h4000},
        {12'hFFF, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 16'h4000},
        {12'h0F0, 1'b1, 1'b1, 1'b1, 12'h333, 1'b0, 12'h0F0, 16'h07E6},
        {12'h000, 1'b0, 1'b0, 1'b1, 12'hFFF, 1'b0, 12'h000, 16'h5FFE}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance n clock edges; inputs change and checks sample at the falling edge
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic pulse_reset_req();
        srst_req = 1'b1;
        step(1);
        srst_req = 1'b0;
        settle();
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        settle();
        chk("R1 drv_en after reset", {4'h0, drv_en}, 16'h0000);
        chk("R1 stat after reset", stat, 16'h0000);

        for (int k = 0; k < 6; k++) begin
            {cmd_on, sw_run, inh_n, olm_en, open_ld, temp_warn} = VEC[k][55:28];
            settle();
            chk("R2/R3/R10/R11 table drv_en", {4'h0, drv_en}, {4'h0, VEC[k][27:16]});
            chk("R2/R3/R10/R11 table stat", stat, VEC[k][15:0]);
            step(1);
        end
        {cmd_on, sw_run, inh_n, olm_en, open_ld, temp_warn} = {12'hFFF, 3'b110, 12'h000, 1'b0};
        settle();
        chk("R3 outputs restored", {4'h0, drv_en}, 16'h0FFF);

        // R4 undervoltage delay of 5 ticks
        sup_uv = 1'b1;
        step(4); settle();
        chk("R4 uv before expiry", {stat[15], 3'b0, drv_en}, 16'h0FFF);
        step(1); settle();
        chk("R4 uv expired", {stat[15], 3'b0, drv_en}, 16'h8000);
        // R5 immediate release, flag held
        sup_uv = 1'b0;
        settle();
        chk("R5 release same cycle", {stat[15], 3'b0, drv_en}, 16'h8FFF);
        step(3); settle();
        chk("R5 flag held", {15'b0, stat[15]}, 16'h0001);
        pulse_reset_req();
        chk("R8 supply flag cleared", {15'b0, stat[15]}, 16'h0000);

        // R4 overvoltage short delay (3)
        dly_long = 1'b0; sup_ov = 1'b1;
        step(2); settle();
        chk("R4 ov short before expiry", {4'h0, drv_en}, 16'h0FFF);
        step(1); settle();
        chk("R4 ov short expired", {4'h0, drv_en}, 16'h0000);
        sup_ov = 1'b0; pulse_reset_req();

        // R4 overvoltage long delay (6)
        dly_long = 1'b1; sup_ov = 1'b1;
        step(5); settle();
        chk("R4 ov long before expiry", {4'h0, drv_en}, 16'h0FFF);
        step(1); settle();
        chk("R4 ov long expired", {stat[15], 3'b0, drv_en}, 16'h8000);
        sup_ov = 1'b0; pulse_reset_req();

        // R4 restart of the supply count
        sup_uv = 1'b1; step(3);
        sup_uv = 1'b0; step(1);
        sup_uv = 1'b1; step(4); settle();
        chk("R4 uv count restarted", {stat[15], 3'b0, drv_en}, 16'h0FFF);
        step(1); settle();
        chk("R4 uv after full window", {stat[15], 3'b0, drv_en}, 16'h8000);
        sup_uv = 1'b0; pulse_reset_req();

        // R6 short delay (4) on low-side switch 1 (index 2)
        dly_long = 1'b0; ovc = 12'h004;
        step(3); settle();
        chk("R6 short before expiry", {stat[13], 3'b0, drv_en}, 16'h0FFF);
        step(1); settle();
        chk("R6 short expired one switch", {stat[13], 3'b0, drv_en}, 16'h8FFB);
        chk("R10 status of shorted switch", stat & 16'h2008, 16'h2000);
        ovc = '0; step(2); settle();
        chk("R8 switch stays off until reset", {4'h0, drv_en}, 16'h0FFB);
        pulse_reset_req();
        chk("R8 short cleared and re-enabled", {stat[13], 3'b0, drv_en}, 16'h0FFF);

        // R6 long delay (8) on index 11
        dly_long = 1'b1; ovc = 12'h800;
        step(7); settle();
        chk("R6 long before expiry", {4'h0, drv_en}, 16'h0FFF);
        step(1); settle();
        chk("R6 long expired", {stat[13], 3'b0, drv_en}, 16'h87FF);
        ovc = '0; pulse_reset_req();

        // R6 restart of the short count
        dly_long = 1'b0; ovc = 12'h001;
        step(3); ovc = '0; step(1); ovc = 12'h001; step(3); settle();
        chk("R6 short count restarted", {stat[13], 3'b0, drv_en}, 16'h0FFF);
        ovc = '0; step(1);

        // R7 prewarning trips at once
        temp_warn = 1'b1; ovc = 12'h010;
        step(1); settle();
        chk("R7 immediate trip", {stat[13], 3'b0, drv_en}, 16'h8FEF);
        chk("R11 prewarn bit", {15'b0, stat[0]}, 16'h0001);
        temp_warn = 1'b0; ovc = '0; pulse_reset_req();

        // R12 no counting without tick
        tick = 1'b0; ovc = 12'h001;
        step(20); settle();
        chk("R12 no tick no trip", {4'h0, drv_en}, 16'h0FFF);
        tick = 1'b1;
        step(3); settle();
        chk("R12 three ticks counted", {4'h0, drv_en}, 16'h0FFF);
        step(1); settle();
        chk("R12 trip at fourth tick", {4'h0, drv_en}, 16'h0FFE);
        ovc = '0; pulse_reset_req();

        // R9 thermal shutdown with interlock
        temp_shut = 1'b1; settle();
        chk("R9 shutdown immediate", stat, 16'hFFFF);
        chk("R9 shutdown enables off", {4'h0, drv_en}, 16'h0000);
        step(1);
        pulse_reset_req();
        chk("R9 reset while hot ignored", {4'h0, drv_en}, 16'h0000);
        temp_shut = 1'b0; step(2); settle();
        chk("R9 cooled but locked", stat, 16'hFFFF);
        pulse_reset_req();
        chk("R9 released after reset", {4'h0, drv_en}, 16'h0FFF);
        chk("R9 status normal", stat, 16'h1FFE);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule